// File: doc/BRIEF.md
# Multi-lane Audio Serial Master

This block is the clock master for a stereo audio serial link in the I2S format. It runs entirely on one master clock of 12.288 MHz, which is 256 times the 48 kHz sample rate. From that clock it derives a bit clock and a frame clock, and it drives both out as registered outputs. A frame is 64 bit-clock periods long. The frame clock is low for the left half and high for the right half. Several output lanes and input lanes share these two clocks. Each lane moves one 24-bit left/right pair per frame, with the most significant bit first.

On the parallel side, each output lane has one holding register for a left/right pair, filled through a valid/ready handshake. At every frame start the lane moves the held pair into its shifter. If nothing is held, the lane sends a frame of zeros and sets a sticky underrun flag. Each input lane assembles the frame it received and presents it through a valid/ready handshake. The enable input parks both clocks high while it is low. On enable, clean frames start, each beginning with the left half.

Top module: `i2s_multilane_master`

## Requirements
- R1: While `enable` is low (sampled at the previous edge), `bclk` and `lrclk` are high and every `sdout` bit is low.
- R2: With `rate_sel` = 0 (48 kHz), `bclk` toggles every 2 clock cycles (period of 4 clocks). With `rate_sel` = 1 (96 kHz), it toggles every cycle (period of 2 clocks).
- R3: A frame is 64 `bclk` periods. `lrclk` changes only together with a `bclk` fall. It is low (left) for bit positions 0..31 and high (right) for 32..63. The first `bclk` fall after enable starts position 0.
- R4: On an output lane, bit position 1 carries left bit 23 and position 24 carries left bit 0. Positions 25..32 are zero. Positions 33..56 carry right bits 23..0, and the rest are zero. `sdout` changes only together with a `bclk` fall.
- R5: `tx_ready[i]` is high exactly when lane i's holding register is empty. A pair on `tx_left[i*24 +: 24]` and `tx_right[i*24 +: 24]` is taken on a clock edge with valid and ready high. The held pair is sent in the next frame that starts after the edge that took it. A pair taken on the frame-start edge itself waits for the following frame.
- R6: A frame that starts with an empty holding register is sent as all zeros, and it sets `tx_underrun[i]`. The flag stays high until `enable` goes low or reset.
- R7: `sdin` is sampled in the cycle where `bclk` rises, using the same bit layout as R4. A complete frame is published on `rx_left`/`rx_right` (lane j at `[j*24 +: 24]`) with `rx_valid[j]` at the `bclk` rise of the next frame's position 0. The partial first frame after enable is never published.
- R8: `rx_valid[j]` and its data stay stable until taken with `rx_ready[j]`. A new frame replaces unread data. A take on the same edge as a new publication leaves `rx_valid` high with the new data.
- R9: All lanes share the clocks, but each lane carries only its own data. A stall or underrun on one lane does not disturb the others.
- R10: After reset, `bclk` and `lrclk` are high, `sdout` is low, `tx_ready` is all ones, and `tx_underrun` and `rx_valid` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (256 x 48 kHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the clocks and lanes when high |
| rate_sel | input | 1 | 0 = 48 kHz, 1 = 96 kHz frame rate |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock, low = left |
| tx_left | input | N_TX*24 | Left samples, lane i at [i*24 +: 24] |
| tx_right | input | N_TX*24 | Right samples, lane i at [i*24 +: 24] |
| tx_valid | input | N_TX | Pair offered, per lane |
| tx_ready | output | N_TX | Holding register empty, per lane |
| tx_underrun | output | N_TX | Sticky underrun flag, per lane |
| sdout | output | N_TX | Serial data out, per lane |
| sdin | input | N_RX | Serial data in, per lane |
| rx_left | output | N_RX*24 | Received left samples |
| rx_right | output | N_RX*24 | Received right samples |
| rx_valid | output | N_RX | Received pair available |
| rx_ready | input | N_RX | Consumer takes the pair |

## Verification
Two pairs of events can fall on the same edge. The first pair is an output lane's frame-start load and a handshake that fills its empty holding register. The second pair is an input lane's publication of a new frame and the consumer's take of the previous one. The bench predicts these edges from its own timing model. It raises `tx_valid` on one lane, and `rx_ready` on another, exactly on those edges. The reference model then requires three things on every cycle. The output lane must send zeros and flag underrun, then send the newly taken pair one frame later. The input lane must keep `rx_valid` high with the fresh data.

// File: rtl/ams_pkg.sv
package ams_pkg;
    typedef enum logic {
        RATE_48K = 1'b0,
        RATE_96K = 1'b1
    } rate_e;
endpackage

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
    import ams_pkg::*;
#(
    parameter int FRAME_BITS = 64,
    parameter int HALF_SLOW  = 2,
    parameter int HALF_FAST  = 1,
    localparam int POS_W     = $clog2(FRAME_BITS),
    localparam int TICK_W    = $clog2(HALF_SLOW) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  rate_e            rate_sel,
    output logic             bclk_o,
    output logic             lrclk_o,
    output logic             fall_evt_o,
    output logic             rise_evt_o,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] pos_nxt_o
);
    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic              bclk;
        logic              lrclk;
        logic [POS_W-1:0]  pos;
    } cg_t;

    cg_t        s_d, s_q;
    int         half_len;
    logic       wrap;
    logic       fall, rise;
    logic [POS_W-1:0] pos_nxt;

    always_comb begin
        half_len = (rate_sel == RATE_96K) ? HALF_FAST : HALF_SLOW;
        wrap     = (int'(s_q.tick) >= half_len - 1);
        fall     = en && wrap && s_q.bclk;
        rise     = en && wrap && !s_q.bclk;
        pos_nxt  = s_q.pos;
        if (fall) begin
            pos_nxt = (s_q.pos == POS_W'(FRAME_BITS - 1)) ? '0 : s_q.pos + 1'b1;
        end

        s_d = s_q;
        if (!en) begin
            s_d.tick  = '0;
            s_d.bclk  = 1'b1;
            s_d.lrclk = 1'b1;
            s_d.pos   = POS_W'(FRAME_BITS - 1);
        end else if (wrap) begin
            s_d.tick = '0;
            s_d.bclk = ~s_q.bclk;
            if (fall) begin
                s_d.pos   = pos_nxt;
                s_d.lrclk = (pos_nxt >= POS_W'(FRAME_BITS / 2));
            end
        end else begin
            s_d.tick = s_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{tick: '0, bclk: 1'b1, lrclk: 1'b1, pos: POS_W'(FRAME_BITS - 1)};
        end else begin
            s_q <= s_d;
        end
    end

    assign bclk_o     = s_q.bclk;
    assign lrclk_o    = s_q.lrclk;
    assign fall_evt_o = fall;
    assign rise_evt_o = rise;
    assign pos_o      = s_q.pos;
    assign pos_nxt_o  = pos_nxt;

    // R1: disabled clocks park high
    p_idle_clocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.bclk && s_q.lrclk));

    // R2: fast rate toggles the bit clock on every master clock
    p_fast_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && ($past(rate_sel) == RATE_96K)) |-> (s_q.bclk != $past(s_q.bclk)));

    // R3: frame clock moves only with a bit clock fall while running
    p_lr_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(s_q.lrclk) && $past(en)) |-> $fell(s_q.bclk));
endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane #(
    parameter int SAMPLE_W    = 24,
    parameter int SLOT_W      = 32,
    localparam int FRAME_BITS = 2 * SLOT_W,
    localparam int PAD_W      = SLOT_W - SAMPLE_W,
    localparam int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                fall_evt,
    input  logic [POS_W-1:0]    pos_nxt,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                sdout,
    output logic                underrun
);
    typedef struct packed {
        logic [SAMPLE_W-1:0]   hold_l;
        logic [SAMPLE_W-1:0]   hold_r;
        logic                  hold_full;
        logic [FRAME_BITS-1:0] shreg;
        logic                  sdout;
        logic                  underrun;
    } tx_t;

    tx_t  s_d, s_q;
    logic frame_start;
    logic accept;

    always_comb begin
        frame_start = fall_evt && (pos_nxt == '0);
        accept      = in_valid && !s_q.hold_full;

        s_d = s_q;
        if (!en) begin
            s_d.sdout    = 1'b0;
            s_d.underrun = 1'b0;
        end else if (frame_start) begin
            s_d.sdout = 1'b0;
            if (s_q.hold_full) begin
                s_d.shreg     = {s_q.hold_l, {PAD_W{1'b0}}, s_q.hold_r, {PAD_W{1'b0}}};
                s_d.hold_full = 1'b0;
            end else begin
                s_d.shreg    = '0;
                s_d.underrun = 1'b1;
            end
        end else if (fall_evt) begin
            s_d.sdout = s_q.shreg[FRAME_BITS-1];
            s_d.shreg = {s_q.shreg[FRAME_BITS-2:0], 1'b0};
        end

        if (accept) begin
            s_d.hold_l    = in_left;
            s_d.hold_r    = in_right;
            s_d.hold_full = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready = !s_q.hold_full;
    assign sdout    = s_q.sdout;
    assign underrun = s_q.underrun;

    // R1: a disabled lane drives low
    p_idle_sdout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !s_q.sdout);

    // R4: serial data moves only with a bit clock fall
    p_sdout_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.sdout) |-> ($past(fall_evt) || !$past(en)));

    // R5: a completed handshake fills the holding register
    p_accept_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R6: underrun stays set while enabled
    p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(s_q.underrun)) |-> s_q.underrun);
endmodule

// File: rtl/i2s_rx_lane.sv
module i2s_rx_lane #(
    parameter int SAMPLE_W    = 24,
    parameter int SLOT_W      = 32,
    localparam int FRAME_BITS = 2 * SLOT_W,
    localparam int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                rise_evt,
    input  logic [POS_W-1:0]    pos,
    input  logic                sdin,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                out_valid,
    input  logic                out_ready
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] shreg;
        logic                  armed;
        logic [SAMPLE_W-1:0]   out_l;
        logic [SAMPLE_W-1:0]   out_r;
        logic                  out_valid;
    } rx_t;

    rx_t  s_d, s_q;
    logic [FRAME_BITS-1:0] sh_next;
    logic publish;

    always_comb begin
        sh_next = {s_q.shreg[FRAME_BITS-2:0], sdin};
        publish = rise_evt && (pos == '0) && s_q.armed;

        s_d = s_q;
        if (!en) begin
            s_d.armed = 1'b0;
        end else if (rise_evt) begin
            s_d.shreg = sh_next;
            if (pos != '0) begin
                s_d.armed = 1'b1;
            end
        end

        if (publish) begin
            s_d.out_l     = sh_next[FRAME_BITS-1 -: SAMPLE_W];
            s_d.out_r     = sh_next[SLOT_W-1 -: SAMPLE_W];
            s_d.out_valid = 1'b1;
        end else if (s_q.out_valid && out_ready) begin
            s_d.out_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_left  = s_q.out_l;
    assign out_right = s_q.out_r;
    assign out_valid = s_q.out_valid;

    // R7: a frame appears only at a bit clock rise
    p_publish_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.out_valid) |-> $past(rise_evt));

    // R8: unread data holds while not taken and not replaced
    p_hold_until_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.out_valid && !out_ready && !publish) |=>
        (s_q.out_valid && $stable(s_q.out_l) && $stable(s_q.out_r)));
endmodule

// File: rtl/i2s_multilane_master.sv
module i2s_multilane_master
    import ams_pkg::*;
#(
    parameter int N_TX      = 4,
    parameter int N_RX      = 2,
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_W    = 32,
    parameter int HALF_SLOW = 2,
    parameter int HALF_FAST = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     rate_sel,
    output logic                     bclk,
    output logic                     lrclk,
    input  logic [N_TX*SAMPLE_W-1:0] tx_left,
    input  logic [N_TX*SAMPLE_W-1:0] tx_right,
    input  logic [N_TX-1:0]          tx_valid,
    output logic [N_TX-1:0]          tx_ready,
    output logic [N_TX-1:0]          tx_underrun,
    output logic [N_TX-1:0]          sdout,
    input  logic [N_RX-1:0]          sdin,
    output logic [N_RX*SAMPLE_W-1:0] rx_left,
    output logic [N_RX*SAMPLE_W-1:0] rx_right,
    output logic [N_RX-1:0]          rx_valid,
    input  logic [N_RX-1:0]          rx_ready
);
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int POS_W      = $clog2(FRAME_BITS);

    logic             fall_evt;
    logic             rise_evt;
    logic [POS_W-1:0] pos_cur;
    logic [POS_W-1:0] pos_nxt;

    i2s_clkgen #(
        .FRAME_BITS (FRAME_BITS),
        .HALF_SLOW  (HALF_SLOW),
        .HALF_FAST  (HALF_FAST)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (enable),
        .rate_sel   (rate_e'(rate_sel)),
        .bclk_o     (bclk),
        .lrclk_o    (lrclk),
        .fall_evt_o (fall_evt),
        .rise_evt_o (rise_evt),
        .pos_o      (pos_cur),
        .pos_nxt_o  (pos_nxt)
    );

    for (genvar gi = 0; gi < N_TX; gi++) begin : g_tx
        i2s_tx_lane #(
            .SAMPLE_W (SAMPLE_W),
            .SLOT_W   (SLOT_W)
        ) u_tx (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (enable),
            .fall_evt (fall_evt),
            .pos_nxt  (pos_nxt),
            .in_left  (tx_left[gi*SAMPLE_W +: SAMPLE_W]),
            .in_right (tx_right[gi*SAMPLE_W +: SAMPLE_W]),
            .in_valid (tx_valid[gi]),
            .in_ready (tx_ready[gi]),
            .sdout    (sdout[gi]),
            .underrun (tx_underrun[gi])
        );
    end

    for (genvar gj = 0; gj < N_RX; gj++) begin : g_rx
        i2s_rx_lane #(
            .SAMPLE_W (SAMPLE_W),
            .SLOT_W   (SLOT_W)
        ) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (enable),
            .rise_evt  (rise_evt),
            .pos       (pos_cur),
            .sdin      (sdin[gj]),
            .out_left  (rx_left[gj*SAMPLE_W +: SAMPLE_W]),
            .out_right (rx_right[gj*SAMPLE_W +: SAMPLE_W]),
            .out_valid (rx_valid[gj]),
            .out_ready (rx_ready[gj])
        );
    end
endmodule

// File: tb/i2s_multilane_master_tb_top.sv
module i2s_multilane_master_tb_top;
    localparam int NTX = 4;
    localparam int NRX = 2;
    localparam int SW  = 24;

    logic clk = 1'b0;
    always #2500ps clk = ~clk;

    logic              rst_n;
    logic              en;
    logic              rate;
    logic              bclk, lrclk;
    logic [NTX*SW-1:0] tx_left, tx_right;
    logic [NTX-1:0]    tx_valid, tx_ready, tx_under, sdout;
    logic [NRX-1:0]    sdin;
    logic [NRX*SW-1:0] rx_left, rx_right;
    logic [NRX-1:0]    rx_valid, rx_ready;

    i2s_multilane_master dut_i (
        .clk(clk), .rst_n(rst_n), .enable(en), .rate_sel(rate),
        .bclk(bclk), .lrclk(lrclk),
        .tx_left(tx_left), .tx_right(tx_right), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_underrun(tx_under), .sdout(sdout),
        .sdin(sdin), .rx_left(rx_left), .rx_right(rx_right),
        .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    int phase = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    int m_tick, m_pos, m_frame;
    bit m_bclk, m_lr, m_idle;
    bit m_full[NTX];
    bit m_sd[NTX];
    bit m_und[NTX];
    logic [SW-1:0] m_hl[NTX], m_hr[NTX], m_cl[NTX], m_cr[NTX];
    int seq[NTX];
    bit m_rv[NRX];
    logic [SW-1:0] m_rl[NRX], m_rr[NRX];

    function automatic logic bit_at(logic [SW-1:0] l, logic [SW-1:0] r, int p);
        int q = (p + 63) % 64;
        int k = q % 32;
        if (k >= SW) return 1'b0;
        return (q < 32) ? l[SW-1-k] : r[SW-1-k];
    endfunction

    function automatic logic [SW-1:0] pat(int lane, int f, int side);
        logic [31:0] v;
        v = 32'(f) * 32'd40503 + 32'(lane) * 32'd7919 + 32'(side) * 32'd104729 + 32'd17;
        v = v * 32'd2654435761;
        return v[31:8];
    endfunction

    function automatic logic [SW-1:0] txval(int lane, int s, int side);
        logic [31:0] v;
        v = 32'(s) * 32'd2246822519 + 32'(lane) * 32'd3266489917
          + 32'(side) * 32'd668265263 + 32'd374761393;
        return v[23:0] ^ v[31:8];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(m_idle ? "R1 bclk" : "R2 bclk", 32'(bclk), 32'(m_bclk));
        chk(m_idle ? "R1 lrclk" : "R3 lrclk", 32'(lrclk), 32'(m_lr));
        for (int i = 0; i < NTX; i++) begin
            chk(m_idle ? $sformatf("R1 sdout lane %0d", i) : $sformatf("R4,R9 sdout lane %0d", i),
                32'(sdout[i]), 32'(m_sd[i]));
            chk($sformatf("R5 tx_ready lane %0d", i), 32'(tx_ready[i]), 32'(!m_full[i]));
            chk($sformatf("R6 underrun lane %0d", i), 32'(tx_under[i]), 32'(m_und[i]));
        end
        for (int j = 0; j < NRX; j++) begin
            chk($sformatf("R8 rx_valid lane %0d", j), 32'(rx_valid[j]), 32'(m_rv[j]));
            if (m_rv[j]) begin
                chk($sformatf("R7,R9 rx_left lane %0d", j), 32'(rx_left[j*SW +: SW]), 32'(m_rl[j]));
                chk($sformatf("R7,R9 rx_right lane %0d", j), 32'(rx_right[j*SW +: SW]), 32'(m_rr[j]));
            end
        end
    endtask

    task automatic tick();
        int  half = rate ? 1 : 2;
        bit  wrap = (m_tick >= half - 1);
        bit  fall = en && wrap && m_bclk;
        bit  rise = en && wrap && !m_bclk;
        int  npos = fall ? (m_pos + 1) % 64 : m_pos;
        bit  fstart = fall && (npos == 0);
        bit  publish = rise && (m_pos == 0) && (m_frame >= 1);
        for (int i = 0; i < NTX; i++) begin
            bit was_full = m_full[i];
            if (!en) begin
                m_sd[i] = 1'b0;
                m_und[i] = 1'b0;
            end else if (fstart) begin
                m_sd[i] = 1'b0;
                if (was_full) begin
                    m_cl[i] = m_hl[i];
                    m_cr[i] = m_hr[i];
                    m_full[i] = 1'b0;
                end else begin
                    m_cl[i] = '0;
                    m_cr[i] = '0;
                    m_und[i] = 1'b1;
                end
            end else if (fall) begin
                m_sd[i] = bit_at(m_cl[i], m_cr[i], npos);
            end
            if (tx_valid[i] && !was_full) begin
                m_hl[i] = tx_left[i*SW +: SW];
                m_hr[i] = tx_right[i*SW +: SW];
                m_full[i] = 1'b1;
                seq[i]++;
            end
        end
        for (int j = 0; j < NRX; j++) begin
            if (publish) begin
                m_rv[j] = 1'b1;
                m_rl[j] = pat(j, m_frame - 1, 0);
                m_rr[j] = pat(j, m_frame - 1, 1);
            end else if (m_rv[j] && rx_ready[j]) begin
                m_rv[j] = 1'b0;
            end
        end
        if (!en) begin
            m_tick = 0; m_bclk = 1'b1; m_lr = 1'b1; m_pos = 63; m_frame = -1;
        end else if (wrap) begin
            m_tick = 0;
            m_bclk = !m_bclk;
            if (fall) begin
                m_pos = npos;
                m_lr = (npos >= 32);
                if (npos == 0) m_frame++;
            end
        end else begin
            m_tick++;
        end
        m_idle = !en;
        @(posedge clk);
        #1ns;
        cyc++;
        compare_all();
        if (fall) begin
            for (int j = 0; j < NRX; j++)
                sdin[j] = bit_at(pat(j, m_frame, 0), pat(j, m_frame, 1), m_pos);
        end
    endtask

    task automatic feed();
        int  half = rate ? 1 : 2;
        bit  wrap = (m_tick >= half - 1);
        bit  fs_next = en && wrap && m_bclk && (m_pos == 63);
        bit  pub_next = en && wrap && !m_bclk && (m_pos == 0) && (m_frame >= 1);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        for (int i = 0; i < NTX; i++) begin
            bit offer;
            if (i == 2 && phase == 0 && m_frame == 1) offer = 1'b0;      // R6 starve lane 2
            else if (i == 3 && phase == 1) offer = fs_next;              // R5 collide with frame start
            else offer = lfsr[i];
            tx_valid[i] = offer;
            tx_left[i*SW +: SW] = txval(i, seq[i], 0);
            tx_right[i*SW +: SW] = txval(i, seq[i], 1);
        end
        if (phase == 0) begin
            rx_ready[0] = 1'b1;
            rx_ready[1] = (lfsr[7:5] == 3'd0);                           // R8 overwrite
        end else begin
            rx_ready[0] = lfsr[4];
            rx_ready[1] = pub_next && m_rv[1];                           // R8 take meets publish
        end
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; rate = 1'b0;
        tx_left = '0; tx_right = '0; tx_valid = '0; rx_ready = '0; sdin = '0;
        m_tick = 0; m_pos = 63; m_frame = -1; m_bclk = 1'b1; m_lr = 1'b1; m_idle = 1'b1;
        for (int i = 0; i < NTX; i++) begin
            m_full[i] = 1'b0; m_sd[i] = 1'b0; m_und[i] = 1'b0;
            m_hl[i] = '0; m_hr[i] = '0; m_cl[i] = '0; m_cr[i] = '0; seq[i] = 0;
        end
        for (int j = 0; j < NRX; j++) begin
            m_rv[j] = 1'b0; m_rl[j] = '0; m_rr[j] = '0;
        end
        repeat (3) @(posedge clk);
        #1ns;
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 bclk", 32'(bclk), 32'd1);
        chk("R10 lrclk", 32'(lrclk), 32'd1);
        chk("R10 sdout", 32'(sdout), 32'd0);
        chk("R10 tx_ready", 32'(tx_ready), 32'hF);
        chk("R10 underrun", 32'(tx_under), 32'd0);
        chk("R10 rx_valid", 32'(rx_valid), 32'd0);

        // preload every lane, then run at 48 kHz
        for (int i = 0; i < NTX; i++) begin
            tx_valid[i] = 1'b1;
            tx_left[i*SW +: SW] = txval(i, seq[i], 0);
            tx_right[i*SW +: SW] = txval(i, seq[i], 1);
        end
        tick();
        tx_valid = '0;
        tick();
        en = 1'b1;
        repeat (6 * 256 + 10) begin feed(); tick(); end

        // R1 idle, R6 flag cleared by disable
        en = 1'b0; tx_valid = '0;
        repeat (8) tick();

        // R2 fast rate with collisions
        rate = 1'b1; phase = 1; en = 1'b1;
        repeat (8 * 128 + 10) begin feed(); tick(); end
        en = 1'b0; tx_valid = '0;
        repeat (4) tick();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100us;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule